// File: doc/BRIEF.md
# Parallel Bus Transaction Sequencer

This block turns requests from an internal port into timed phases on a general-purpose external parallel interface. Each request carries a direction, an address and write data. The block places the data and the address side by side on one shared 32-pin vector. The widths of the two fields come from a data-size code and an address-size code. It drives separate read and write strobes. It can also drive a bus clock on the top pin, either running all the time or only while a transaction is active.

Writes run in one of two styles:
- **Single-cycle style:** a setup phase, then a strobe phase, with the address and the data present together.
- **Two-cycle style:** an address phase with the write strobe high, then a data phase with the strobe low.

Reads use a setup phase and then a read-strobe phase. The block samples the data pins as it leaves the read-strobe phase.

A clock-enable tick is supplied from outside and paces the bus. A phase advances only on a tick that arrives while the external ready input is high.

Back-pressure on the request side follows valid/ready rules. A request is taken in the cycle where `req_valid` and `req_ready` are both high. The caller must hold `req_*` stable while `req_valid` is high and `req_ready` is low. The response path has no back-pressure: read data appears for exactly one cycle with `rsp_valid`.

Top module: `pbus_seq`

## Requirements
- R1: Data-size code `cfg_dsize` 0/1/2/3 selects 8/16/24/32 data bits. These bits occupy pins 0 upward. They are driven (output enable high) for every phase of a write and are never driven during a read.
- R2: Address-size code `cfg_asize` 0/1/2/3 selects 0/4/12/20 address bits. The least significant address bits sit on the pins directly above the data field. They are driven in every non-idle phase. Pins above the address field are undriven and low.
- R3: The size combination is illegal in any of these cases: `cfg_asize`=2 with `cfg_dsize`=2; `cfg_asize`=3 with `cfg_dsize`≠0; `cfg_dsize`=3 with `cfg_asize`≠0; `cfg_dsize`=3 with `cfg_clk_en`=1. An illegal combination raises `config_error` and holds `req_ready` low, so no request is accepted.
- R4: A write with `cfg_wr2cyc`=0 first passes through a setup phase, with the write strobe low and the address and data on the pins. It then passes through a strobe phase with `wr_strobe` high and the same pin values, then returns to idle.
- R5: A write with `cfg_wr2cyc`=1 has two phases. The address phase has `wr_strobe` high and the data field driven to zero. The following data phase has `wr_strobe` low, the write data on the data field and the address field driven to zero.
- R6: When `cfg_clk_en`=1, pin 31 is driven and is high for the one cycle that follows each tick. With `cfg_clk_gate`=1, only ticks taken while a transaction is in progress produce a pulse, and pin 31 stays low otherwise. `cfg_clk_gate` has no effect when `cfg_div_zero`=1. When `cfg_clk_en`=0, pin 31 carries no clock.
- R7: A phase advances only on a cycle with `tick`=1 and `ext_ready`=1. Otherwise the phase, the pins and the strobes hold.
- R8: A read first passes through a setup phase with both strobes low, then a phase with `rd_strobe` high. When that phase advances, the data-field bits of `pin_in` are captured. They are presented zero-extended on `rsp_rdata`, with `rsp_valid` high for exactly the next cycle.
- R9: `req_ready` is high only when the block is idle and the configuration is legal. After reset the block is idle with both strobes low, no pin driven by the data or address fields, and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bus clock-enable tick |
| cfg_dsize | input | 2 | Data-size code |
| cfg_asize | input | 2 | Address-size code |
| cfg_clk_en | input | 1 | Drive the bus clock on pin 31 |
| cfg_clk_gate | input | 1 | Gate the bus clock to active transactions |
| cfg_div_zero | input | 1 | Bus clock divider is zero (gating ignored) |
| cfg_wr2cyc | input | 1 | Two-cycle write style |
| config_error | output | 1 | Illegal size combination |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 32 | Read data |
| ext_ready | input | 1 | External ready, low stretches the phase |
| pin_in | input | 32 | Pin input values |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| wr_strobe | output | 1 | Write strobe |
| rd_strobe | output | 1 | Read strobe |

## Verification
The bench targets five corner cases:
- **Packing boundaries:** 24-bit data with a 4-bit address, and 8-bit data with a 20-bit address. A packer with an off-by-one shift would show the address one pin high or overlapping the data.
- **Two-cycle write:** a design that kept the address on the pins in the data phase, or left the strobe high there, would differ from the reference model on the pins.
- **Gated versus free clock around idle periods, including the divider-zero override:** this exposes pulses that appear while idle or go missing during a transaction.
- **Ready stalls landing on a tick:** these catch a phase that advances early.
- **Every size combination with the clock on and off:** a request offered in each illegal case must stay unaccepted, so a mis-coded legality rule either blocks good traffic or lets an overlapping layout through.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_WSTB,
    PH_RSTB,
    PH_ADDR,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/pbus_cfg_check.sv
module pbus_cfg_check #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic [1:0]       dsize,
  input  logic [1:0]       asize,
  input  logic             clk_en,
  output logic [CNT_W-1:0] dbits,
  output logic [CNT_W-1:0] abits,
  output logic             illegal
);
  always_comb begin
    dbits = CNT_W'((32'(dsize) + 32'd1) * 32'(BYTE_W));
    unique case (asize)
      2'd0: abits = CNT_W'(0);
      2'd1: abits = CNT_W'(4);
      2'd2: abits = CNT_W'(12);
      default: abits = CNT_W'(20);
    endcase
    illegal = 1'b0;
    if (asize == 2'd2 && dsize == 2'd2) illegal = 1'b1;
    if (asize == 2'd3 && dsize != 2'd0) illegal = 1'b1;
    if (dsize == 2'd3 && (asize != 2'd0 || clk_en)) illegal = 1'b1;
  end
endmodule

// File: rtl/pbus_clk_gen.sv
module pbus_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clk_en,
  input  logic gate,
  input  logic div_zero,
  input  logic busy,
  output logic bclk
);
  logic pulse_d;

  always_comb pulse_d = tick && clk_en && (!gate || div_zero || busy);

  always_ff @(posedge clk) begin
    if (!rst_n) bclk <= 1'b0;
    else        bclk <= pulse_d;
  end

  // R6: a clock pulse only follows a tick
  a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $past(tick));
  // R6: gated clock stays low while idle
  a_r6_gated_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && gate && !div_zero && !busy) |=> !bclk);
endmodule

// File: rtl/pbus_pin_pack.sv
module pbus_pin_pack #(
  parameter int PIN_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 7
) (
  input  logic [CNT_W-1:0]  dbits,
  input  logic [CNT_W-1:0]  abits,
  input  logic              data_oe,
  input  logic              addr_oe,
  input  logic [DATA_W-1:0] data_val,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              clk_en,
  input  logic              bclk,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [DATA_W-1:0] dmask
);
  localparam int CLK_PIN = PIN_W - 1;

  logic [ADDR_W-1:0] amask;
  logic [PIN_W-1:0]  addr_wide;
  logic [CNT_W-1:0]  atop;

  always_comb begin
    for (int j = 0; j < ADDR_W; j++) amask[j] = (CNT_W'(j) < abits);
    addr_wide = PIN_W'(addr_val & amask) << dbits;
    atop = dbits + abits;
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    logic in_data, in_addr, fld_out, fld_oe;
    always_comb begin
      in_data = IDX < dbits;
      in_addr = !in_data && (IDX < atop);
    end
    if (i < DATA_W) begin : g_d
      always_comb begin
        fld_out = in_data ? data_val[i] : (in_addr ? addr_wide[i] : 1'b0);
        fld_oe  = in_data ? data_oe : (in_addr ? addr_oe : 1'b0);
      end
    end else begin : g_a
      always_comb begin
        fld_out = in_addr ? addr_wide[i] : 1'b0;
        fld_oe  = in_addr ? addr_oe : 1'b0;
      end
    end
    if (i == CLK_PIN) begin : g_clk
      always_comb begin
        pin_out[i] = clk_en ? bclk : fld_out;
        pin_oe[i]  = clk_en ? 1'b1 : fld_oe;
      end
    end else begin : g_io
      always_comb begin
        pin_out[i] = fld_out;
        pin_oe[i]  = fld_oe;
      end
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    always_comb dmask[k] = (CNT_W'(k) < dbits);
  end

  // R1 R2: with no field enabled, nothing below the clock pin is driven
  always_comb begin
    if (!data_oe && !addr_oe)
      a_r2_idle_undriven: assert (pin_oe[PIN_W-2:0] == '0);
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_dsize,
  input  logic [1:0]        cfg_asize,
  input  logic              cfg_clk_en,
  input  logic              cfg_clk_gate,
  input  logic              cfg_div_zero,
  input  logic              cfg_wr2cyc,
  output logic              config_error,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ext_ready,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              wr_strobe,
  output logic              rd_strobe
);
  localparam int CNT_W = $clog2(PIN_W) + 2;

  phase_e            phase;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  dbits, abits;
  logic [DATA_W-1:0] dmask, data_val;
  logic [ADDR_W-1:0] addr_val;
  logic              busy, adv, accept, bclk, data_oe;

  pbus_cfg_check #(.BYTE_W(8), .CNT_W(CNT_W)) u_cfg (
    .dsize(cfg_dsize), .asize(cfg_asize), .clk_en(cfg_clk_en),
    .dbits(dbits), .abits(abits), .illegal(config_error)
  );

  pbus_clk_gen u_clk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_en(cfg_clk_en),
    .gate(cfg_clk_gate), .div_zero(cfg_div_zero), .busy(busy), .bclk(bclk)
  );

  always_comb begin
    busy      = (phase != PH_IDLE);
    adv       = tick && ext_ready;
    req_ready = !busy && !config_error;
    accept    = req_valid && req_ready;
    wr_strobe = (phase == PH_WSTB) || (phase == PH_ADDR);
    rd_strobe = (phase == PH_RSTB);
    data_oe   = busy && write_q;
    data_val  = (data_oe && phase != PH_ADDR) ? wdata_q : '0;
    addr_val  = (busy && phase != PH_DATA) ? addr_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          write_q <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          phase   <= (req_write && cfg_wr2cyc) ? PH_ADDR : PH_SETUP;
        end
        PH_SETUP: if (adv) phase <= write_q ? PH_WSTB : PH_RSTB;
        PH_WSTB:  if (adv) phase <= PH_IDLE;
        PH_RSTB:  if (adv) begin
          phase     <= PH_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= pin_in[DATA_W-1:0] & dmask;
        end
        PH_ADDR:  if (adv) phase <= PH_DATA;
        PH_DATA:  if (adv) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  pbus_pin_pack #(.PIN_W(PIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pack (
    .dbits(dbits), .abits(abits), .data_oe(data_oe), .addr_oe(busy),
    .data_val(data_val), .addr_val(addr_val), .clk_en(cfg_clk_en), .bclk(bclk),
    .pin_out(pin_out), .pin_oe(pin_oe), .dmask(dmask)
  );

  // R3 R9: an illegal layout never offers readiness
  a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !req_ready);
  // R4 R5 R8: strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && rd_strobe));
  // R8: the response is a single-cycle pulse
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7: a stalled phase keeps its pins and strobes
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext_ready && $stable(cfg_dsize) && $stable(cfg_asize)) |=>
      ($stable(pin_out[PIN_W-2:0]) && $stable(wr_strobe) && $stable(rd_strobe)));
  // R8: a response follows a read strobe phase
  a_r8_rsp_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(rd_strobe));
endmodule

// File: tb/pbus_seq_test.sv
`timescale 1ns/1ps
module pbus_seq_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] cfg_dsize = 0, cfg_asize = 0;
  logic cfg_clk_en = 0, cfg_clk_gate = 0, cfg_div_zero = 0, cfg_wr2cyc = 0;
  logic config_error, req_ready, rsp_valid, wr_strobe, rd_strobe;
  logic req_valid = 0, req_write = 0, ext_ready = 1;
  logic [19:0] req_addr = 0;
  logic [31:0] req_wdata = 0, pin_in = 0, rsp_rdata, pin_out, pin_oe;

  int tests = 0, fails = 0;
  int tick_div = 3, tcnt = 0, stall_mode = 0, scnt = 0;
  string cur = "R9";

  always #2.5 clk = ~clk;

  pbus_seq uut (.*);

  // stimulus for the tick and ready inputs
  always @(posedge clk) begin
    #1;
    tcnt = (tcnt + 1) % tick_div;
    tick = (tcnt == 0);
    scnt = (scnt + 1) % 7;
    ext_ready = (stall_mode != 0) ? (scnt >= 4) : 1'b1;
  end

  // reference model
  int m_ph = 0; // 0 idle 1 setup 2 wstrobe 3 rstrobe 4 addr 5 data
  bit m_w, m_bclk, m_rv;
  bit [19:0] m_addr;
  bit [31:0] m_wd, m_rd;

  function automatic bit legal(int d, int a, bit ck);
    if (a == 2 && d == 2) return 0;
    if (a == 3 && d != 0) return 0;
    if (d == 3 && (a != 0 || ck)) return 0;
    return 1;
  endfunction

  function automatic int dbw(); return 8 * (int'(cfg_dsize) + 1); endfunction
  function automatic int abw();
    case (cfg_asize) 0: return 0; 1: return 4; 2: return 12; default: return 20; endcase
  endfunction

  always @(posedge clk) begin
    bit adv, rdy;
    if (!rst_n) begin
      m_ph = 0; m_w = 0; m_bclk = 0; m_rv = 0; m_addr = 0; m_wd = 0; m_rd = 0;
    end else begin
      adv = tick && ext_ready;
      rdy = (m_ph == 0) && legal(cfg_dsize, cfg_asize, cfg_clk_en);
      m_bclk = tick && cfg_clk_en && (!cfg_clk_gate || cfg_div_zero || m_ph != 0);
      m_rv = 0;
      case (m_ph)
        0: if (req_valid && rdy) begin
             m_w = req_write; m_addr = req_addr; m_wd = req_wdata;
             m_ph = (req_write && cfg_wr2cyc) ? 4 : 1;
           end
        1: if (adv) m_ph = m_w ? 2 : 3;
        2: if (adv) m_ph = 0;
        3: if (adv) begin
             m_ph = 0; m_rv = 1; m_rd = 0;
             for (int i = 0; i < dbw(); i++) m_rd[i] = pin_in[i];
           end
        4: if (adv) m_ph = 5;
        5: if (adv) m_ph = 0;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, cur, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit [31:0] eo, ee;
    int db, ab;
    if (rst_n) begin
      db = dbw(); ab = abw(); eo = 0; ee = 0;
      for (int i = 0; i < 32; i++) begin
        if (i < db) begin
          ee[i] = (m_ph != 0) && m_w;
          eo[i] = ee[i] && m_ph != 4 ? m_wd[i] : 1'b0;
        end else if (i < db + ab) begin
          ee[i] = (m_ph != 0);
          eo[i] = ee[i] && m_ph != 5 ? m_addr[i - db] : 1'b0;
        end
      end
      if (cfg_clk_en) begin ee[31] = 1; eo[31] = m_bclk; end
      chk("R1 R2 pin_out", {32'd0, pin_out}, {32'd0, eo});
      chk("R1 R2 pin_oe", {32'd0, pin_oe}, {32'd0, ee});
      chk("R4 R5 wr_strobe", 64'(wr_strobe), 64'(m_ph == 2 || m_ph == 4));
      chk("R8 rd_strobe", 64'(rd_strobe), 64'(m_ph == 3));
      chk("R9 req_ready", 64'(req_ready), 64'(m_ph == 0 && legal(cfg_dsize, cfg_asize, cfg_clk_en)));
      chk("R3 config_error", 64'(config_error), 64'(!legal(cfg_dsize, cfg_asize, cfg_clk_en)));
      chk("R8 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk("R8 rsp_rdata", {32'd0, rsp_rdata}, {32'd0, m_rd});
    end
  end

  task automatic do_req(bit w, logic [19:0] a, logic [31:0] d);
    int n = 0;
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready && ++n < 1000);
    @(posedge clk); #1;
    req_valid = 0;
    n = 0;
    do @(negedge clk); while (!req_ready && ++n < 2000);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(int d, int a, bit ck, bit g, bit dz, bit w2);
    @(posedge clk); #1;
    cfg_dsize = 2'(d); cfg_asize = 2'(a); cfg_clk_en = ck;
    cfg_clk_gate = g; cfg_div_zero = dz; cfg_wr2cyc = w2;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur = "R9 reset";
    chk("R9 reset req_ready", 64'(req_ready), 64'd1);
    chk("R9 reset pin_oe", {32'd0, pin_oe}, 64'd0);
    chk("R9 reset strobes", 64'({wr_strobe, rd_strobe, rsp_valid}), 64'd0);

    cur = "R1 R2 R4 single write d8 a20";
    set_cfg(0, 3, 0, 0, 0, 0);
    do_req(1, 20'hABCDE, 32'h1234_565A);
    cur = "R1 R2 R4 single write d16 a12";
    set_cfg(1, 2, 0, 0, 0, 0);
    do_req(1, 20'h00F3C, 32'h0000_BEEF);

    cur = "R8 R6 read d16 a12 free clock";
    pin_in = 32'hFFFF_1234;
    set_cfg(1, 2, 1, 0, 0, 0);
    do_req(0, 20'h00ABC, 32'h0);
    repeat (10) @(negedge clk);

    cur = "R5 R6 two-cycle write d24 a4 gated clock";
    tick_div = 2;
    set_cfg(2, 1, 1, 1, 0, 1);
    repeat (6) @(negedge clk);
    do_req(1, 20'h0000B, 32'h00C0_FFEE);
    cur = "R8 R6 read in two-cycle style gated";
    pin_in = 32'h5AA5_C3E1;
    do_req(0, 20'h00007, 32'h0);

    cur = "R7 stalls";
    stall_mode = 1; tick_div = 1;
    do_req(1, 20'h00005, 32'h0077_8899);
    set_cfg(0, 3, 0, 0, 0, 0);
    do_req(0, 20'hFEDCB, 32'h0);
    set_cfg(1, 0, 1, 0, 0, 0);
    do_req(1, 20'h0, 32'hA5A5_F00D);
    stall_mode = 0; tick_div = 3;

    cur = "R6 divider-zero override";
    set_cfg(0, 1, 1, 1, 1, 0);
    repeat (12) @(negedge clk);

    cur = "R3 legality sweep";
    for (int ck = 0; ck < 2; ck++)
      for (int d = 0; d < 4; d++)
        for (int a = 0; a < 4; a++) begin
          set_cfg(d, a, ck[0], 0, 0, 0);
          @(negedge clk);
          chk("R3 sweep config_error", 64'(config_error), 64'(!legal(d, a, ck[0])));
          if (!legal(d, a, ck[0])) begin
            @(posedge clk); #1;
            req_valid = 1; req_write = 1; req_addr = 20'h3; req_wdata = 32'hFF;
            repeat (4) @(negedge clk);
            chk("R3 illegal request not taken", {32'd0, pin_oe}, 64'(ck ? 32'h8000_0000 : 0));
            @(posedge clk); #1 req_valid = 0;
          end
        end

    cur = "R1 32-bit data";
    set_cfg(3, 0, 0, 0, 0, 0);
    pin_in = 32'h8765_4321;
    do_req(1, 20'h0, 32'hDEAD_BEEF);
    do_req(0, 20'h0, 32'h0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired [%s] actual=hung expected=done", cur);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule